// File: doc/BRIEF.md
# Watchdog Timer with Interval Prescaler

This block guards a processor against a hung program. A free-running 8-bit interval timer, fed by a programmable power-of-two divider of the system clock, wraps around at a steady rate. Software has no way to stop it. Each wrap advances a watchdog counter. The watchdog counter then measures how many interval-timer wraps have occurred since software last serviced the watchdog.

When the number of wraps since the last service reaches a programmable limit, a time-out occurs. A control bit selects what the time-out does. In reset mode it raises a reset request, which stays high until the system reset arrives. In interrupt mode it sets an interrupt flag and restarts the count. Software services the watchdog with a write that clears the counter, and it must repeat that write within every detection period.

The current interval-timer value is visible on an output, so the timebase can be observed.

Top module: `wdg_interval_watchdog`

## Requirements
- R1: The interval timer (`bt_value`) advances by one each time the divider expires, and wraps from 255 to 0. No write stops it or changes it.
- R2: The watchdog counter advances by one on each cycle in which the interval timer wraps from 255 to 0.
- R3: A time-out occurs on the wrap that brings the count since the last clear up to the limit. A limit of 0 means 128 wraps.
- R4: In reset mode a time-out drives `wdt_reset_req` high. It stays high until `rst_n` is low at a clock edge.
- R5: In interrupt mode a time-out sets `wdt_irq` and clears the watchdog counter, which then counts again from zero. `wdt_reset_req` stays low.
- R6: A write with `wr_sel`=0 loads `wr_data[6:0]` as the new limit. If `wr_data[7]`=1 it also clears the watchdog counter, and that clear wins over a wrap in the same cycle. If `wr_data[7]`=0 the count is kept.
- R7: `wdt_irq` stays set until a write with `wr_sel`=1 and `wr_data[4]`=1 clears it. A time-out in the same cycle keeps it set.
- R8: A write with `wr_sel`=1 sets the mode from `wr_data[0]` (1 = reset mode, 0 = interrupt mode). It sets the divider select `s` from `wr_data[3:1]`, which gives a divider period of 2^(3+s) clock cycles (8 to 1024).
- R9: While `rst_n` is low at a clock edge, both counters clear, reset mode is chosen, the limit becomes 127, the divider select becomes 0, and both outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = limit/clear register, 1 = control register |
| wr_data | input | 8 | Write data |
| bt_value | output | 8 | Current interval-timer value |
| wdt_reset_req | output | 1 | Sticky reset request (reset mode time-out) |
| wdt_irq | output | 1 | Watchdog interrupt flag (interrupt mode time-out) |

## Verification
The bench builds the block with its defaults: an 8-bit interval timer, a 7-bit watchdog counter and limit, and a 3-bit divider select. It drives only the two shortest divider settings, so one interval-timer wrap takes 2048 or 4096 cycles. At those rates, limits of one to three wraps, refresh clears just ahead of a time-out, and both time-out modes all fit in a short run. A cycle-level reference model in the bench predicts the timer value and both outputs on every cycle. Directed cases add checks on the divider rate, on the time-out window after a clear, and on whether the flag holds.

// File: rtl/wdg_pkg.sv
// Package: shared definitions for the interval-prescaled watchdog.
// Assumes: register targets are selected by a single select bit.
package wdg_pkg;
    // Register target selected by the write port select bit.
    typedef enum logic {
        WR_LIMIT = 1'b0,
        WR_CTRL  = 1'b1
    } wr_target_e;

    // Bit positions inside the control register write.
    localparam int CTRL_MODE_BIT   = 0;
    localparam int CTRL_SEL_LSB    = 1;
    localparam int CTRL_IRQCLR_BIT = 4;
endpackage

// File: rtl/wdg_prescaler.sv
// Module: wdg_prescaler
// Divides the system clock by a power of two picked by sel_i and emits a
// one-cycle tick at the end of each period of 2^(MIN_LOG2+sel_i) cycles.
// Assumes: the free-running divider is never reset except by rst_n.
module wdg_prescaler #(
    parameter int SEL_W    = 3,
    parameter int MIN_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;

    logic [MAX_LOG2-1:0] div_q;
    logic [MAX_LOG2-1:0] mask;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Build the mask of low bits that must all be one for the selected ratio.
    always_comb begin
        for (int i = 0; i < MAX_LOG2; i++) begin
            mask[i] = (i < MIN_LOG2 + int'(sel_i));
        end
    end

    // Tick when the selected low bits are all ones.
    assign tick_o = ((div_q & mask) == mask);
endmodule

// File: rtl/wdg_interval_timer.sv
// Module: wdg_interval_timer
// Free-running interval timer advanced by the prescaler tick; flags the
// wrap from all ones to zero as an overflow pulse.
// Assumes: tick_i is a single-cycle pulse; no software control exists.
module wdg_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] value_o,
    output logic         ovf_o
);
    logic [W-1:0] bt_q;

    // Count prescaler ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      bt_q <= '0;
        else if (tick_i) bt_q <= bt_q + 1'b1;
    end

    // Overflow is the tick that wraps the timer.
    assign ovf_o   = tick_i & (&bt_q);
    assign value_o = bt_q;

    AST_TIMER_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> bt_q == W'($past(bt_q) + 1'b1)); // R1
    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(bt_q)); // R1
endmodule

// File: rtl/wdg_watch_counter.sv
// Module: wdg_watch_counter
// Counts interval-timer overflows and compares the count to a limit.
// A time-out sets a sticky reset request in reset mode, or sets the
// interrupt flag and restarts the count in interrupt mode.
// Assumes: clr_i and irq_clr_i are single-cycle write pulses.
module wdg_watch_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf_i,
    input  logic             clr_i,
    input  logic             irq_clr_i,
    input  logic             rst_mode_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             req_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;

    // Next count and the time-out event (a clear suppresses it).
    assign cnt_nxt = CNT_W'(cnt_q + 1'b1);
    assign hit     = ovf_i && !clr_i && (cnt_nxt == limit_i);

    // Watchdog counter: clear first, then restart on interrupt time-out.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clr_i)                cnt_q <= '0;
        else if (hit && !rst_mode_i)   cnt_q <= '0;
        else if (ovf_i)                cnt_q <= cnt_nxt;
    end

    // Sticky reset request, released only by system reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  req_o <= 1'b0;
        else if (hit && rst_mode_i)  req_o <= 1'b1;
    end

    // Interrupt flag: set on time-out (wins), cleared by software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq_o <= 1'b0;
        else if (hit && !rst_mode_i)  irq_o <= 1'b1;
        else if (irq_clr_i)           irq_o <= 1'b0;
    end

    AST_COUNT_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i && !clr_i && rst_mode_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0); // R6
    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> req_o); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !irq_clr_i |=> irq_o); // R7
    AST_IRQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i && !clr_i && !rst_mode_i && cnt_nxt == limit_i |=> irq_o && cnt_q == '0); // R5
endmodule

// File: rtl/wdg_interval_watchdog.sv
// Module: wdg_interval_watchdog (top)
// Watchdog built from a clock prescaler, a free-running interval timer and
// an overflow counter with a programmable limit. Decodes a small write
// port into limit/clear and control (mode, divider, flag clear) actions.
// Assumes: synchronous active-low reset; writes are single-cycle strobes.
module wdg_interval_watchdog
    import wdg_pkg::*;
#(
    parameter int BT_W     = 8,
    parameter int CNT_W    = 7,
    parameter int SEL_W    = 3,
    parameter int MIN_LOG2 = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [7:0]      wr_data,
    output logic [BT_W-1:0] bt_value,
    output logic            wdt_reset_req,
    output logic            wdt_irq
);
    localparam logic [CNT_W-1:0] LIMIT_RST = '1;

    logic             wr_limit, wr_ctrl;
    logic             cnt_clr, irq_clr;
    logic [CNT_W-1:0] limit_q;
    logic             rst_mode_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick, ovf;

    // Decode write targets and strobes.
    assign wr_limit = wr_en && (wr_target_e'(wr_sel) == WR_LIMIT);
    assign wr_ctrl  = wr_en && (wr_target_e'(wr_sel) == WR_CTRL);
    assign cnt_clr  = wr_limit && wr_data[7];
    assign irq_clr  = wr_ctrl && wr_data[CTRL_IRQCLR_BIT];

    // Limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= LIMIT_RST;
        else if (wr_limit) limit_q <= wr_data[CNT_W-1:0];
    end

    // Control register: mode and divider select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_mode_q <= 1'b1;
            sel_q      <= '0;
        end else if (wr_ctrl) begin
            rst_mode_q <= wr_data[CTRL_MODE_BIT];
            sel_q      <= wr_data[CTRL_SEL_LSB +: SEL_W];
        end
    end

    wdg_prescaler #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .tick_o(tick)
    );

    wdg_interval_timer #(.W(BT_W)) u_bt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .value_o(bt_value), .ovf_o(ovf)
    );

    wdg_watch_counter #(.CNT_W(CNT_W)) u_wc (
        .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .clr_i(cnt_clr),
        .irq_clr_i(irq_clr), .rst_mode_i(rst_mode_q), .limit_i(limit_q),
        .req_o(wdt_reset_req), .irq_o(wdt_irq)
    );

    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_mode_q && !$past(wdt_reset_req) && wdt_reset_req |-> $stable(wdt_irq)); // R4
    AST_OVF_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> bt_value == '0); // R2
endmodule

// File: tb/tb_wdg_interval_watchdog.sv
module tb_wdg_interval_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] bt_value;
    logic       wdt_reset_req, wdt_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    wdg_interval_watchdog dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bt_value(bt_value),
        .wdt_reset_req(wdt_reset_req), .wdt_irq(wdt_irq)
    );

    // ---------------- reference model built from the requirements ----------
    logic [9:0] m_div;
    logic [7:0] m_bt;
    logic [6:0] m_cnt, m_lim;
    logic       m_mode, m_req, m_irq;
    logic [2:0] m_sel;

    function automatic logic m_tick(input logic [9:0] d, input logic [2:0] s);
        logic [9:0] mk = 10'((1 << (3 + s)) - 1);
        return (d & mk) == mk;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div <= '0; m_bt <= '0; m_cnt <= '0; m_lim <= 7'h7F;
            m_mode <= 1'b1; m_sel <= '0; m_req <= 1'b0; m_irq <= 1'b0;
        end else begin
            logic t, o, clr, h;
            t   = m_tick(m_div, m_sel);
            o   = t && (m_bt == 8'hFF);
            clr = wr_en && !wr_sel && wr_data[7];
            h   = o && !clr && (7'(m_cnt + 1) == m_lim);
            m_div <= m_div + 1'b1;
            if (t) m_bt <= m_bt + 1'b1;
            if (clr) m_cnt <= '0;
            else if (h && !m_mode) m_cnt <= '0;
            else if (o) m_cnt <= 7'(m_cnt + 1);
            if (h && m_mode) m_req <= 1'b1;
            if (h && !m_mode) m_irq <= 1'b1;
            else if (wr_en && wr_sel && wr_data[4]) m_irq <= 1'b0;
            if (wr_en && !wr_sel) m_lim <= wr_data[6:0];
            if (wr_en && wr_sel) begin m_mode <= wr_data[0]; m_sel <= wr_data[3:1]; end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check(bt_value == m_bt, "R1 timer", bt_value, m_bt);
            check(wdt_irq == m_irq, "R2 R3 R5 R7 irq", wdt_irq, m_irq);
            check(wdt_reset_req == m_req, "R4 req", wdt_reset_req, m_req);
        end
    end

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // Watchdog on the run itself.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, b0;
        void'($urandom(32'd2024));
        idle(3);
        // R9: reset state
        check(wdt_reset_req == 0 && wdt_irq == 0, "R9 outputs", wdt_reset_req, 0);
        check(bt_value == 0, "R9 timer", bt_value, 0);
        rst_n = 1'b1;

        // R8: divider select 1 gives a period of 16 cycles
        wr(1'b1, 8'b0000_0011);
        idle(2);
        b0 = bt_value; idle(32);
        check(8'(bt_value - b0) == 2, "R8 div16", 8'(bt_value - b0), 2);
        wr(1'b1, 8'b0000_0001);
        b0 = bt_value; idle(32);
        check(8'(bt_value - b0) == 4, "R8 div8", 8'(bt_value - b0), 4);

        // R3/R5: interrupt mode, limit 3, time-out window after clear
        wr(1'b1, 8'b0000_0000);
        wr(1'b0, 8'h83);
        t0 = cyc;
        while (!wdt_irq && cyc - t0 < 8000) @(negedge clk);
        check(cyc - t0 > 2 * 2048 && cyc - t0 <= 3 * 2048 + 2, "R3 window", cyc - t0, 3 * 2048);
        check(wdt_reset_req == 0, "R5 no req", wdt_reset_req, 0);
        idle(3000);
        // R7: flag still held
        check(wdt_irq == 1, "R7 hold", wdt_irq, 1);
        wr(1'b1, 8'b0001_0000);
        idle(1);
        check(wdt_irq == 0, "R7 clear", wdt_irq, 0);

        // R6: refresh inside the period, reset mode, limit 2
        do_reset();
        wr(1'b1, 8'b0000_0001);
        wr(1'b0, 8'h82);
        for (int i = 0; i < 6; i++) begin
            idle(2000);
            wr(1'b0, 8'h82);
        end
        check(wdt_reset_req == 0, "R6 refresh", wdt_reset_req, 0);
        // R6: limit write without clear keeps the count; R4 request follows
        wr(1'b0, 8'h02);
        idle(4200);
        check(wdt_reset_req == 1, "R4 timeout", wdt_reset_req, 1);
        wr(1'b0, 8'h81);
        idle(5);
        check(wdt_reset_req == 1, "R4 sticky", wdt_reset_req, 1);
        do_reset();
        idle(1);
        check(wdt_reset_req == 0, "R9 release", wdt_reset_req, 0);

        // Random mix compared against the model
        for (int i = 0; i < 40; i++) begin
            int k = $urandom_range(0, 9);
            if (k < 4)      wr(1'b0, {1'($urandom_range(0, 1)), 7'($urandom_range(1, 3))});
            else if (k < 7) wr(1'b1, {3'b000, 1'($urandom_range(0, 1)), 2'b00,
                                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))});
            else if (k < 8) do_reset();
            idle($urandom_range(50, 2500));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule